// File: doc/BRIEF.md
# Debug-Mode Entry and Debug Register Unit

This block is the debug-control slice of a small in-order core. It owns a debug control word, a debug return PC and a debug scratch word. It also owns the machine trap registers it must update: the trap vector, the exception PC, the trap cause and the faulting address. When the core raises a trap, the block decides in the same cycle where execution goes next. A breakpoint whose per-privilege enable is set stops the core in debug mode. Any other trap takes the normal machine trap path. A trap raised while the core is already in debug goes to a separate debug-ROM exception entry.

The decision is made by a two-state machine. `ST_RUN` is normal execution and `ST_DEBUG` is the state after a debug entry. The transition ENTER (`ST_RUN` to `ST_DEBUG`) fires on a breakpoint trap whose enable matches the current privilege. STAY_RUN covers every other cycle in `ST_RUN`, including machine traps. STAY_DEBUG covers every cycle in `ST_DEBUG`; the only way out is a reset (RESET, either reset input, back to `ST_RUN`). The control word's cause field is nonzero exactly while the machine is in `ST_DEBUG`.

The unit has two synchronous resets. Power-on reset loads the halt flag from a halt request strap. Warm reset clears the halt flag whatever the strap says, so the strap acts only once. A CSR port reads combinationally and writes at the clock edge. It flags any access to an address the unit does not hold.

Top module: `dbgctl_unit`

## Requirements
- R1: A trap whose cause equals `BRK_CAUSE` (default 3), taken in `ST_RUN`, enters debug only if the enable bit for `prv_i` is set. The enables are control word bits 15 (machine, prv 3), 14 (hypervisor, prv 2), 13 (supervisor, prv 1) and 12 (user, prv 0). Otherwise the trap is handled as a machine trap.
- R2: On debug entry, `redirect_o`=1, `next_pc_o`=`ROM_START` and `next_prv_o`=3 in the trap cycle. After the clock edge: the debug PC holds `pc_i`, control word bits [8:6] hold 1, and control word bits [1:0] hold the `prv_i` of the trap cycle.
- R3: A machine trap gives `redirect_o`=1, `next_pc_o`=trap vector and `next_prv_o`=3. At the edge it writes `trap_epc_i` into the exception PC and the zero-extended cause into the cause register. It writes the faulting-address register only when `trap_bad_valid_i` is 1.
- R4: While the cause field is nonzero, any trap gives `next_pc_o`=`ROM_EXC` and `next_prv_o`=`prv_i`. It changes no register, and the state leaves debug only through a reset.
- R5: Power-on reset (`por_i`) loads halt (control word bit 3) from `halt_req_i`. Warm reset (`rst_i`) clears halt. Both resets clear the cause, the enables, step, prv, the debug PC, the debug scratch word and the machine trap registers, and set the trap vector to `MTVEC_RST`.
- R6: A control word read (address 0x7B0) returns fixed values in several fields: bits [31:30]=1, bits [29:16]=0, bits [11:9]=0, bit 4=0 and all bits above 31 = 0. Bit 5 shows the live `dbg_irq_i`.
- R7: A control word write changes only prv [1:0], step [2], halt [3] and the enables [15:12]. The cause field and the fixed fields keep their values.
- R8: Debug PC (0x7B1), debug scratch (0x7B2), trap vector (0x305), exception PC (0x341), cause (0x342) and faulting address (0x343) are full-width read/write registers.
- R9: A read or write to any other address sets `csr_illegal_o` in that cycle. Such a read returns 0 and such a write changes nothing.
- R10: A CSR write in a cycle with `trap_valid_i`=1 is discarded.
- R11: With no trap, `redirect_o`=0, `next_pc_o`=`pc_i` and `next_prv_o`=`prv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Synchronous power-on reset, active high |
| rst_i | input | 1 | Synchronous warm reset, active high |
| halt_req_i | input | 1 | Halt request strap sampled at power-on reset |
| trap_valid_i | input | 1 | A trap is raised this cycle |
| trap_cause_i | input | CAUSE_W | Trap cause code |
| trap_epc_i | input | XLEN | PC of the trapping instruction |
| trap_bad_valid_i | input | 1 | Trap carries a faulting address |
| trap_bad_addr_i | input | XLEN | Faulting address |
| pc_i | input | XLEN | Current PC |
| prv_i | input | 2 | Current privilege (U=0, S=1, H=2, M=3) |
| dbg_irq_i | input | 1 | Live debug interrupt line for this hart |
| csr_re_i | input | 1 | CSR read strobe |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| csr_illegal_o | output | 1 | Access to an address the unit does not hold |
| redirect_o | output | 1 | `next_pc_o` is a trap target |
| next_pc_o | output | XLEN | Next PC |
| next_prv_o | output | 2 | Next privilege |

## Verification
A CSR write and a trap can arrive in the same cycle. This happens, for example, when the instruction that writes the debug scratch word or the control word faults. The bench provokes this with directed cases and also lets random stimulus raise a trap and a write together. It then reads the target register back. The write must have been dropped, while the trap's own updates (debug entry, machine trap or ROM exception) must be exactly those of a trap alone.

// File: rtl/dbgctl_pkg.sv
`timescale 1ns/1ps
package dbgctl_pkg;

    typedef enum logic {
        ST_RUN,
        ST_DEBUG
    } dstate_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ENTER,
        ACT_MTRAP,
        ACT_ROMEXC
    } act_e;

    // Control word fields held in flops; fixed fields are produced on read.
    typedef struct packed {
        logic [3:0] ebk;    // index = privilege code
        logic [2:0] cause;
        logic       halt;
        logic       step;
        logic [1:0] prv;
    } dctl_t;

    localparam logic [1:0]  PRV_MACH    = 2'd3;
    localparam logic [2:0]  CAUSE_SWBRK = 3'd1;
    localparam logic [1:0]  DBG_VER     = 2'd1;

    localparam logic [11:0] CA_DCTL   = 12'h7B0;
    localparam logic [11:0] CA_DPC    = 12'h7B1;
    localparam logic [11:0] CA_DSCR   = 12'h7B2;
    localparam logic [11:0] CA_MTVEC  = 12'h305;
    localparam logic [11:0] CA_MEPC   = 12'h341;
    localparam logic [11:0] CA_MCAUSE = 12'h342;
    localparam logic [11:0] CA_MBAD   = 12'h343;

endpackage

// File: rtl/dbgctl_fsm.sv
`timescale 1ns/1ps
module dbgctl_fsm
    import dbgctl_pkg::*;
#(
    parameter int                 XLEN      = 64,
    parameter int                 CAUSE_W   = 4,
    parameter int                 BRK_CAUSE = 3,
    parameter logic [XLEN-1:0]    ROM_START = 'h800,
    parameter logic [XLEN-1:0]    ROM_EXC   = 'h808
) (
    input  logic                clk_i,
    input  logic                rst_any_i,
    input  logic                trap_valid_i,
    input  logic [CAUSE_W-1:0]  trap_cause_i,
    input  logic [1:0]          prv_i,
    input  logic [3:0]          ebk_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [XLEN-1:0]     mtvec_i,
    output dstate_e             state_o,
    output act_e                act_o,
    output logic                redirect_o,
    output logic [XLEN-1:0]     next_pc_o,
    output logic [1:0]          next_prv_o
);

    dstate_e state_q, state_d;
    logic    brk_hit;

    assign brk_hit = (trap_cause_i == CAUSE_W'(BRK_CAUSE)) && ebk_i[prv_i];

    // State register: RESET returns to ST_RUN.
    always_ff @(posedge clk_i) begin
        if (rst_any_i) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ENTER, STAY_RUN, STAY_DEBUG.
    always_comb begin
        state_d = state_q;
        act_o   = ACT_NONE;
        unique case (state_q)
            ST_RUN: begin
                if (trap_valid_i) begin
                    if (brk_hit) begin
                        act_o   = ACT_ENTER;
                        state_d = ST_DEBUG;
                    end else begin
                        act_o   = ACT_MTRAP;
                    end
                end
            end
            ST_DEBUG: begin
                if (trap_valid_i) begin
                    act_o = ACT_ROMEXC;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Outputs from the chosen action.
    always_comb begin
        redirect_o = 1'b1;
        next_pc_o  = pc_i;
        next_prv_o = prv_i;
        unique case (act_o)
            ACT_NONE: begin
                redirect_o = 1'b0;
            end
            ACT_ENTER: begin
                next_pc_o  = ROM_START;
                next_prv_o = PRV_MACH;
            end
            ACT_MTRAP: begin
                next_pc_o  = mtvec_i;
                next_prv_o = PRV_MACH;
            end
            ACT_ROMEXC: begin
                next_pc_o  = ROM_EXC;
            end
            default: begin
                redirect_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/dbgctl_regs.sv
`timescale 1ns/1ps
module dbgctl_regs
    import dbgctl_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              CAUSE_W   = 4,
    parameter logic [XLEN-1:0] MTVEC_RST = 'h100
) (
    input  logic                clk_i,
    input  logic                por_i,
    input  logic                rst_i,
    input  logic                halt_req_i,
    input  act_e                act_i,
    input  logic [CAUSE_W-1:0]  trap_cause_i,
    input  logic [XLEN-1:0]     trap_epc_i,
    input  logic                trap_bad_valid_i,
    input  logic [XLEN-1:0]     trap_bad_addr_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [1:0]          prv_i,
    input  logic                csr_we_i,
    input  logic [11:0]         csr_addr_i,
    input  logic [XLEN-1:0]     csr_wdata_i,
    output dctl_t               dctl_o,
    output logic [XLEN-1:0]     dpc_o,
    output logic [XLEN-1:0]     dscr_o,
    output logic [XLEN-1:0]     mtvec_o,
    output logic [XLEN-1:0]     mepc_o,
    output logic [XLEN-1:0]     mcause_o,
    output logic [XLEN-1:0]     mbad_o
);

    dctl_t           dctl_q;
    logic [XLEN-1:0] dpc_q, dscr_q, mtvec_q, mepc_q, mcause_q, mbad_q;

    always_ff @(posedge clk_i) begin
        if (por_i || rst_i) begin
            dctl_q   <= '{ebk: 4'b0, cause: 3'b0, halt: por_i & halt_req_i,
                          step: 1'b0, prv: 2'b0};
            dpc_q    <= '0;
            dscr_q   <= '0;
            mtvec_q  <= MTVEC_RST;
            mepc_q   <= '0;
            mcause_q <= '0;
            mbad_q   <= '0;
        end else begin
            unique case (act_i)
                ACT_ENTER: begin
                    dctl_q.cause <= CAUSE_SWBRK;
                    dctl_q.prv   <= prv_i;
                    dpc_q        <= pc_i;
                end
                ACT_MTRAP: begin
                    mepc_q   <= trap_epc_i;
                    mcause_q <= XLEN'(trap_cause_i);
                    if (trap_bad_valid_i) begin
                        mbad_q <= trap_bad_addr_i;
                    end
                end
                ACT_ROMEXC: begin
                end
                ACT_NONE: begin
                    // Writes retire only when no trap is taken.
                    if (csr_we_i) begin
                        case (csr_addr_i)
                            CA_DCTL: begin
                                dctl_q.prv  <= csr_wdata_i[1:0];
                                dctl_q.step <= csr_wdata_i[2];
                                dctl_q.halt <= csr_wdata_i[3];
                                dctl_q.ebk  <= csr_wdata_i[15:12];
                            end
                            CA_DPC:    dpc_q    <= csr_wdata_i;
                            CA_DSCR:   dscr_q   <= csr_wdata_i;
                            CA_MTVEC:  mtvec_q  <= csr_wdata_i;
                            CA_MEPC:   mepc_q   <= csr_wdata_i;
                            CA_MCAUSE: mcause_q <= csr_wdata_i;
                            CA_MBAD:   mbad_q   <= csr_wdata_i;
                            default: begin
                            end
                        endcase
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign dctl_o   = dctl_q;
    assign dpc_o    = dpc_q;
    assign dscr_o   = dscr_q;
    assign mtvec_o  = mtvec_q;
    assign mepc_o   = mepc_q;
    assign mcause_o = mcause_q;
    assign mbad_o   = mbad_q;

endmodule

// File: rtl/dbgctl_rdmux.sv
`timescale 1ns/1ps
module dbgctl_rdmux
    import dbgctl_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             csr_re_i,
    input  logic             csr_we_i,
    input  logic [11:0]      csr_addr_i,
    input  logic             dbg_irq_i,
    input  dctl_t            dctl_i,
    input  logic [XLEN-1:0]  dpc_i,
    input  logic [XLEN-1:0]  dscr_i,
    input  logic [XLEN-1:0]  mtvec_i,
    input  logic [XLEN-1:0]  mepc_i,
    input  logic [XLEN-1:0]  mcause_i,
    input  logic [XLEN-1:0]  mbad_i,
    output logic [XLEN-1:0]  csr_rdata_o,
    output logic             csr_illegal_o
);

    logic hit;

    always_comb begin
        csr_rdata_o = '0;
        hit         = 1'b1;
        case (csr_addr_i)
            CA_DCTL: begin
                csr_rdata_o[31:30] = DBG_VER;
                csr_rdata_o[15:12] = dctl_i.ebk;
                csr_rdata_o[8:6]   = dctl_i.cause;
                csr_rdata_o[5]     = dbg_irq_i;
                csr_rdata_o[3]     = dctl_i.halt;
                csr_rdata_o[2]     = dctl_i.step;
                csr_rdata_o[1:0]   = dctl_i.prv;
            end
            CA_DPC:    csr_rdata_o = dpc_i;
            CA_DSCR:   csr_rdata_o = dscr_i;
            CA_MTVEC:  csr_rdata_o = mtvec_i;
            CA_MEPC:   csr_rdata_o = mepc_i;
            CA_MCAUSE: csr_rdata_o = mcause_i;
            CA_MBAD:   csr_rdata_o = mbad_i;
            default:   hit = 1'b0;
        endcase
    end

    assign csr_illegal_o = (csr_re_i || csr_we_i) && !hit;

endmodule

// File: rtl/dbgctl_unit.sv
`timescale 1ns/1ps
module dbgctl_unit
    import dbgctl_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              CAUSE_W   = 4,
    parameter int              BRK_CAUSE = 3,
    parameter logic [XLEN-1:0] ROM_START = 'h800,
    parameter logic [XLEN-1:0] ROM_EXC   = 'h808,
    parameter logic [XLEN-1:0] MTVEC_RST = 'h100
) (
    input  logic                clk_i,
    input  logic                por_i,
    input  logic                rst_i,
    input  logic                halt_req_i,
    input  logic                trap_valid_i,
    input  logic [CAUSE_W-1:0]  trap_cause_i,
    input  logic [XLEN-1:0]     trap_epc_i,
    input  logic                trap_bad_valid_i,
    input  logic [XLEN-1:0]     trap_bad_addr_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [1:0]          prv_i,
    input  logic                dbg_irq_i,
    input  logic                csr_re_i,
    input  logic                csr_we_i,
    input  logic [11:0]         csr_addr_i,
    input  logic [XLEN-1:0]     csr_wdata_i,
    output logic [XLEN-1:0]     csr_rdata_o,
    output logic                csr_illegal_o,
    output logic                redirect_o,
    output logic [XLEN-1:0]     next_pc_o,
    output logic [1:0]          next_prv_o
);

    logic            rst_any_w;
    dstate_e         state_w;
    act_e            act_w;
    dctl_t           dctl_w;
    logic [XLEN-1:0] dpc_w, dscr_w, mtvec_w, mepc_w, mcause_w, mbad_w;

    assign rst_any_w = por_i || rst_i;

    dbgctl_fsm #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .BRK_CAUSE(BRK_CAUSE),
        .ROM_START(ROM_START), .ROM_EXC(ROM_EXC)
    ) fsm_i (
        .clk_i(clk_i), .rst_any_i(rst_any_w),
        .trap_valid_i(trap_valid_i), .trap_cause_i(trap_cause_i),
        .prv_i(prv_i), .ebk_i(dctl_w.ebk), .pc_i(pc_i), .mtvec_i(mtvec_w),
        .state_o(state_w), .act_o(act_w), .redirect_o(redirect_o),
        .next_pc_o(next_pc_o), .next_prv_o(next_prv_o)
    );

    dbgctl_regs #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .MTVEC_RST(MTVEC_RST)
    ) regs_i (
        .clk_i(clk_i), .por_i(por_i), .rst_i(rst_i), .halt_req_i(halt_req_i),
        .act_i(act_w), .trap_cause_i(trap_cause_i), .trap_epc_i(trap_epc_i),
        .trap_bad_valid_i(trap_bad_valid_i), .trap_bad_addr_i(trap_bad_addr_i),
        .pc_i(pc_i), .prv_i(prv_i), .csr_we_i(csr_we_i),
        .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i),
        .dctl_o(dctl_w), .dpc_o(dpc_w), .dscr_o(dscr_w), .mtvec_o(mtvec_w),
        .mepc_o(mepc_w), .mcause_o(mcause_w), .mbad_o(mbad_w)
    );

    dbgctl_rdmux #(
        .XLEN(XLEN)
    ) rdmux_i (
        .csr_re_i(csr_re_i), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
        .dbg_irq_i(dbg_irq_i), .dctl_i(dctl_w), .dpc_i(dpc_w),
        .dscr_i(dscr_w), .mtvec_i(mtvec_w), .mepc_i(mepc_w),
        .mcause_i(mcause_w), .mbad_i(mbad_w),
        .csr_rdata_o(csr_rdata_o), .csr_illegal_o(csr_illegal_o)
    );

endmodule

// File: rtl/dbgctl_chk.sv
`timescale 1ns/1ps
module dbgctl_chk
    import dbgctl_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              CAUSE_W   = 4,
    parameter int              BRK_CAUSE = 3,
    parameter logic [XLEN-1:0] ROM_START = 'h800,
    parameter logic [XLEN-1:0] ROM_EXC   = 'h808
) (
    input logic               clk_i,
    input logic               por_i,
    input logic               rst_i,
    input logic               trap_valid_i,
    input logic [CAUSE_W-1:0] trap_cause_i,
    input logic [1:0]         prv_i,
    input logic [XLEN-1:0]    pc_i,
    input dstate_e            state_i,
    input dctl_t              dctl_i,
    input logic [XLEN-1:0]    dpc_i,
    input logic [XLEN-1:0]    mepc_i,
    input logic [XLEN-1:0]    mcause_i,
    input logic [XLEN-1:0]    dscr_i,
    input logic               csr_re_i,
    input logic               csr_we_i,
    input logic [11:0]        csr_addr_i,
    input logic [31:0]        csr_rdata_i,
    input logic               csr_illegal_i,
    input logic               dbg_irq_i,
    input logic               redirect_i,
    input logic [XLEN-1:0]    next_pc_i,
    input logic [1:0]         next_prv_i
);

    logic brk_en, known;

    assign brk_en = trap_valid_i && (trap_cause_i == CAUSE_W'(BRK_CAUSE))
                    && dctl_i.ebk[prv_i];
    assign known  = csr_addr_i inside {CA_DCTL, CA_DPC, CA_DSCR, CA_MTVEC,
                                       CA_MEPC, CA_MCAUSE, CA_MBAD};

    p_disabled_brk_r1: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (state_i == ST_RUN && trap_valid_i && !brk_en) |=> (state_i == ST_RUN));

    p_enter_target_r2: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (state_i == ST_RUN && brk_en) |-> (redirect_i && next_pc_i == ROM_START
                                           && next_prv_i == 2'd3));

    p_enter_save_r2: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (state_i == ST_RUN && brk_en) |=> (state_i == ST_DEBUG && dpc_i == $past(pc_i)
            && dctl_i.cause == 3'd1 && dctl_i.prv == $past(prv_i)));

    p_rom_exc_r4: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (state_i == ST_DEBUG && trap_valid_i) |-> (next_pc_i == ROM_EXC));

    p_debug_quiet_r4: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (state_i == ST_DEBUG && trap_valid_i) |=> ($stable(mepc_i) && $stable(mcause_i)
                                                   && $stable(dpc_i)));

    p_dctl_fixed_r6: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (csr_re_i && csr_addr_i == CA_DCTL) |-> (csr_rdata_i[31:28] == 4'b0100
            && csr_rdata_i[10:9] == 2'b00 && csr_rdata_i[5] == dbg_irq_i));

    p_illegal_r9: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        ((csr_re_i || csr_we_i) && !known) |-> csr_illegal_i);

    p_squash_r10: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (trap_valid_i && csr_we_i) |=> $stable(dscr_i));

    p_idle_r11: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        !trap_valid_i |-> (!redirect_i && next_pc_i == pc_i && next_prv_i == prv_i));

endmodule

bind dbgctl_unit dbgctl_chk #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .BRK_CAUSE(BRK_CAUSE),
    .ROM_START(ROM_START), .ROM_EXC(ROM_EXC)
) chk_i (
    .clk_i(clk_i), .por_i(por_i), .rst_i(rst_i), .trap_valid_i(trap_valid_i),
    .trap_cause_i(trap_cause_i), .prv_i(prv_i), .pc_i(pc_i),
    .state_i(state_w), .dctl_i(dctl_w), .dpc_i(dpc_w), .mepc_i(mepc_w),
    .mcause_i(mcause_w), .dscr_i(dscr_w), .csr_re_i(csr_re_i),
    .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
    .csr_rdata_i(csr_rdata_o[31:0]), .csr_illegal_i(csr_illegal_o),
    .dbg_irq_i(dbg_irq_i), .redirect_i(redirect_o), .next_pc_i(next_pc_o),
    .next_prv_i(next_prv_o)
);

// File: tb/dbgctl_unit_tb_top.sv
`timescale 1ns/1ps
module dbgctl_unit_tb_top;

    localparam int          XLEN    = 64;
    localparam int          CAUSE_W = 4;
    localparam int          BRK     = 3;
    localparam logic [63:0] ROM_S   = 64'h800;
    localparam logic [63:0] ROM_E   = 64'h808;
    localparam logic [63:0] MTV_RST = 64'h100;

    localparam logic [11:0] A_DCTL = 12'h7B0, A_DPC = 12'h7B1, A_DSCR = 12'h7B2;
    localparam logic [11:0] A_MTVEC = 12'h305, A_MEPC = 12'h341;
    localparam logic [11:0] A_MCAUSE = 12'h342, A_MBAD = 12'h343;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic por_i = 1'b1, rst_i = 1'b0, halt_req_i = 1'b0;
    logic trap_valid_i = 1'b0, trap_bad_valid_i = 1'b0, dbg_irq_i = 1'b0;
    logic [CAUSE_W-1:0] trap_cause_i = '0;
    logic [63:0] trap_epc_i = '0, trap_bad_addr_i = '0, pc_i = '0, csr_wdata_i = '0;
    logic [1:0]  prv_i = '0;
    logic csr_re_i = 1'b0, csr_we_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [63:0] csr_rdata_o, next_pc_o;
    logic        csr_illegal_o, redirect_o;
    logic [1:0]  next_prv_o;

    dbgctl_unit #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .BRK_CAUSE(BRK),
        .ROM_START(ROM_S), .ROM_EXC(ROM_E), .MTVEC_RST(MTV_RST)
    ) dut_i (
        .clk_i(clk), .por_i(por_i), .rst_i(rst_i), .halt_req_i(halt_req_i),
        .trap_valid_i(trap_valid_i), .trap_cause_i(trap_cause_i),
        .trap_epc_i(trap_epc_i), .trap_bad_valid_i(trap_bad_valid_i),
        .trap_bad_addr_i(trap_bad_addr_i), .pc_i(pc_i), .prv_i(prv_i),
        .dbg_irq_i(dbg_irq_i), .csr_re_i(csr_re_i), .csr_we_i(csr_we_i),
        .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i),
        .csr_rdata_o(csr_rdata_o), .csr_illegal_o(csr_illegal_o),
        .redirect_o(redirect_o), .next_pc_o(next_pc_o), .next_prv_o(next_prv_o)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // Reference state built from the requirements
    logic [63:0] m_dpc, m_dscr, m_mtvec, m_mepc, m_mcause, m_mbad;
    logic [3:0]  m_ebk;
    logic [2:0]  m_cause;
    logic        m_halt, m_step;
    logic [1:0]  m_prv;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_dctl();
        logic [63:0] v = '0;
        v[31:30] = 2'd1;
        v[15:12] = m_ebk;
        v[8:6]   = m_cause;
        v[5]     = dbg_irq_i;
        v[3]     = m_halt;
        v[2]     = m_step;
        v[1:0]   = m_prv;
        return v;
    endfunction

    function automatic bit known(logic [11:0] a);
        return a inside {A_DCTL, A_DPC, A_DSCR, A_MTVEC, A_MEPC, A_MCAUSE, A_MBAD};
    endfunction

    function automatic logic [63:0] exp_rd(logic [11:0] a);
        case (a)
            A_DCTL:   return exp_dctl();
            A_DPC:    return m_dpc;
            A_DSCR:   return m_dscr;
            A_MTVEC:  return m_mtvec;
            A_MEPC:   return m_mepc;
            A_MCAUSE: return m_mcause;
            A_MBAD:   return m_mbad;
            default:  return '0;
        endcase
    endfunction

    function automatic logic [11:0] pick_addr(int i);
        case (i % 8)
            0: return A_DCTL;   1: return A_DPC;    2: return A_DSCR;
            3: return A_MTVEC;  4: return A_MEPC;   5: return A_MCAUSE;
            6: return A_MBAD;   default: return 12'h7B3;
        endcase
    endfunction

    task automatic model_reset(bit por, bit hreq);
        m_dpc = '0; m_dscr = '0; m_mtvec = MTV_RST; m_mepc = '0;
        m_mcause = '0; m_mbad = '0; m_ebk = '0; m_cause = '0;
        m_halt = por & hreq; m_step = 1'b0; m_prv = '0;
    endtask

    task automatic do_reset(bit por, bit hreq);
        @(negedge clk);
        por_i = por; rst_i = !por; halt_req_i = hreq;
        trap_valid_i = 1'b0; csr_we_i = 1'b0;
        @(posedge clk);
        model_reset(por, hreq);
        @(negedge clk);
        por_i = 1'b0; rst_i = 1'b0; halt_req_i = !hreq;
    endtask

    // Combinational read, called at a falling edge
    task automatic rd(logic [11:0] a, string tag);
        csr_re_i = 1'b1; csr_addr_i = a;
        #1;
        chk(tag, csr_rdata_o, exp_rd(a));
        chk("R9", csr_illegal_o, !known(a));
        csr_re_i = 1'b0;
    endtask

    task automatic step(bit tv, logic [3:0] c, logic [63:0] epc, bit bv,
                        logic [63:0] ba, logic [63:0] pc, logic [1:0] p,
                        bit we, logic [11:0] a, logic [63:0] wd);
        logic [63:0] e_pc;
        logic [1:0]  e_prv;
        bit          e_red, enter;
        string       tg;
        trap_valid_i = tv; trap_cause_i = c; trap_epc_i = epc;
        trap_bad_valid_i = bv; trap_bad_addr_i = ba; pc_i = pc; prv_i = p;
        csr_we_i = we; csr_addr_i = a; csr_wdata_i = wd;
        enter = tv && (m_cause == 0) && (c == BRK) && m_ebk[p];
        if (!tv) begin
            e_red = 0; e_pc = pc; e_prv = p; tg = "R11";
        end else if (m_cause != 0) begin
            e_red = 1; e_pc = ROM_E; e_prv = p; tg = "R4";
        end else if (enter) begin
            e_red = 1; e_pc = ROM_S; e_prv = 2'd3; tg = "R2";
        end else begin
            e_red = 1; e_pc = m_mtvec; e_prv = 2'd3;
            tg = (c == BRK) ? "R1" : "R3";
        end
        #1;
        chk(tg, redirect_o, e_red);
        chk(tg, next_pc_o, e_pc);
        chk(tg, next_prv_o, e_prv);
        chk("R9", csr_illegal_o, we && !known(a));
        @(posedge clk);
        if (tv) begin
            if (m_cause != 0) begin
            end else if (enter) begin
                m_cause = 3'd1; m_prv = p; m_dpc = pc;
            end else begin
                m_mepc = epc; m_mcause = 64'(c);
                if (bv) m_mbad = ba;
            end
        end else if (we) begin
            case (a)
                A_DCTL: begin
                    m_prv = wd[1:0]; m_step = wd[2]; m_halt = wd[3]; m_ebk = wd[15:12];
                end
                A_DPC:    m_dpc = wd;
                A_DSCR:   m_dscr = wd;
                A_MTVEC:  m_mtvec = wd;
                A_MEPC:   m_mepc = wd;
                A_MCAUSE: m_mcause = wd;
                A_MBAD:   m_mbad = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        trap_valid_i = 1'b0; csr_we_i = 1'b0; trap_bad_valid_i = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R5: power-on reset with the halt strap set
        do_reset(1'b1, 1'b1);
        rd(A_DCTL, "R5");
        rd(A_MTVEC, "R5");
        rd(A_DPC, "R5");
        // R5: a warm reset clears halt even with the strap set
        do_reset(1'b0, 1'b1);
        rd(A_DCTL, "R5");

        // R11: idle cycle passes PC and privilege through
        step(0, 0, 0, 0, 0, 64'h4000, 2'd1, 0, A_DPC, 0);

        // R7: write all ones, only writable fields take
        step(0, 0, 0, 0, 0, 64'h10, 2'd3, 1, A_DCTL, '1);
        rd(A_DCTL, "R7");

        // R1: machine-only enable, breakpoint at supervisor is a machine trap
        step(0, 0, 0, 0, 0, 64'h10, 2'd3, 1, A_DCTL, 64'h8000);
        step(1, 4'(BRK), 64'h2220, 0, 0, 64'h2220, 2'd1, 0, A_DPC, 0);
        rd(A_MEPC, "R1");
        rd(A_MCAUSE, "R1");

        // R3: bad address only when flagged
        step(1, 4'd5, 64'h3330, 1, 64'hDEAD_BEEF, 64'h3330, 2'd0, 0, A_DPC, 0);
        rd(A_MBAD, "R3");
        step(1, 4'd2, 64'h4440, 0, 64'h1111, 64'h4440, 2'd0, 0, A_DPC, 0);
        rd(A_MBAD, "R3");
        rd(A_MCAUSE, "R3");

        // R10: write during a trap is discarded
        step(1, 4'd7, 64'h5550, 0, 0, 64'h5550, 2'd0, 1, A_DSCR, 64'hAAAA_5555);
        rd(A_DSCR, "R10");

        // R8: plain registers read back
        step(0, 0, 0, 0, 0, 0, 0, 1, A_DPC, 64'h0123_4567_89AB_CDEF);
        rd(A_DPC, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, A_DSCR, 64'hFEDC_BA98_7654_3210);
        rd(A_DSCR, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, A_MTVEC, 64'h9000);
        rd(A_MTVEC, "R8");

        // R9: unknown address
        rd(12'h123, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 12'h7B3, 64'h1);

        // R6: live debug interrupt bit
        dbg_irq_i = 1'b1; rd(A_DCTL, "R6");
        dbg_irq_i = 1'b0; rd(A_DCTL, "R6");

        // R2: enter debug from user with user enable
        step(0, 0, 0, 0, 0, 0, 0, 1, A_DCTL, 64'h1000);
        step(1, 4'(BRK), 64'h7770, 0, 0, 64'h7770, 2'd0, 0, A_DPC, 0);
        rd(A_DPC, "R2");
        rd(A_DCTL, "R2");

        // R4: traps inside debug go to the ROM exception entry
        step(1, 4'd5, 64'h8880, 1, 64'h55, 64'h8880, 2'd3, 0, A_DPC, 0);
        rd(A_MEPC, "R4");
        rd(A_MBAD, "R4");
        step(1, 4'(BRK), 64'h9990, 0, 0, 64'h9990, 2'd0, 0, A_DPC, 0);
        rd(A_DPC, "R4");
        // R7: cause field ignores a write
        step(0, 0, 0, 0, 0, 0, 0, 1, A_DCTL, 64'h1C0);
        rd(A_DCTL, "R7");
        // R10: control word write during a debug trap is dropped
        step(1, 4'd1, 0, 0, 0, 0, 2'd2, 1, A_DCTL, 64'hF00F);
        rd(A_DCTL, "R10");

        // Random phase
        for (int i = 0; i < 600; i++) begin
            int kind = $urandom % 10;
            logic [63:0] rpc = {$urandom, $urandom};
            logic [1:0]  rp  = 2'($urandom);
            if (i % 30 == 29) do_reset(($urandom % 4) == 0, 1'($urandom));
            dbg_irq_i = 1'($urandom);
            if (kind < 4) begin
                logic [3:0] c = (($urandom % 2) == 0) ? 4'(BRK) : 4'($urandom);
                step(1, c, rpc, 1'($urandom), {$urandom, $urandom}, rpc, rp,
                     ($urandom % 3) == 0, pick_addr($urandom), {$urandom, $urandom});
            end else if (kind < 8) begin
                step(0, 0, 0, 0, 0, rpc, rp, 1, pick_addr($urandom),
                     {$urandom, $urandom});
            end else begin
                step(0, 0, 0, 0, 0, rpc, rp, 0, A_DPC, 0);
            end
            rd(pick_addr($urandom), "R8");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule